// File: doc/BRIEF.md
# Tri-Speed Forwarded Clock and Enable Generator

This block sits at the front of a tri-speed serial gigabit media adaptation layer. It runs from a single 125 MHz reference clock. From that clock it builds two single-bit clock halves that a downstream double-data-rate output register merges into the forwarded interface clock. It also drives one clock-enable strobe that the transmit and receive data adapters use to qualify reference cycles.

A two-bit speed select picks one of three rates. At gigabit rate the halves sit at fixed levels, so the DDR register emits the inverse of the reference clock, and the enable stays high. At 100 Mb/s and 10 Mb/s one shared divide counter sets the toggle points of the halves. The forwarded clock is then the reference divided by 10 or by 100, with a 50 percent duty cycle. The enable pulses once per forwarded period, in the reference cycle where the forwarded clock falls.

A synchronous reset clears the generator. So does any change of the decoded speed. The halves are forced low and the counter restarts, and no enable strobe appears until the new mode has produced its first complete forwarded period.

Top module: `sgmii_rate_clkgen`

## Requirements
- R1: Speed select encoding: 2'b00 selects 10 Mb/s, 2'b01 selects 100 Mb/s, and 2'b10 or 2'b11 selects 1 Gb/s.
- R2: At 1 Gb/s, outside the restart cycle, `clk_half_rise` is 0 and `clk_half_fall` is 1, so the merged clock is the inverse of `clk_ref`.
- R3: At 1 Gb/s, outside the restart cycle, `clk_en` is 1 in every reference cycle.
- R4: At 100 Mb/s, `clk_half_rise` toggles every 5 reference cycles, giving a 10-cycle period and 5 cycles high.
- R5: At 10 Mb/s, `clk_half_rise` toggles every 50 reference cycles, giving a 100-cycle period and 50 cycles high.
- R6: In the divided modes, `clk_half_fall` is registered on the falling edge of `clk_ref` and carries the value that `clk_half_rise` holds in that same reference cycle (a half-period delay).
- R7: In the divided modes, `clk_en` is high for exactly one reference cycle per forwarded period (every 10 or every 100 cycles). That cycle is the first cycle in which `clk_half_rise` is 0 after being 1.
- R8: Reset, or a change of the decoded speed, clears the counter and drives both halves and `clk_en` to 0 for one cycle. In a divided mode the halves then rise after half a period, and the first `clk_en` comes one full period after the restart cycle.
- R9: Changing `speed_sel` between two encodings that decode to the same speed causes no restart, and the outputs continue without interruption.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | 125 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_sel | input | 2 | Speed select (encoding in R1) |
| clk_half_rise | output | 1 | Forwarded-clock half for the DDR rising-edge data input, registered on the rising edge |
| clk_half_fall | output | 1 | Forwarded-clock half for the DDR falling-edge data input, registered on the falling edge |
| clk_en | output | 1 | Reference-cycle qualifier, one cycle per forwarded period in the divided modes |

## Verification
Each divided mode is entered from a different previous speed. The period and high time of the forwarded clock are measured cycle by cycle, which separates a wrong divisor from a wrong toggle point. Enable strobes are checked for spacing and for placement at the high-to-low transition, and the first strobe after a restart is checked for being withheld, which exposes a counter that is not cleared. Switching between the two gigabit encodings must leave the steady enable unbroken, while a mid-run reset must zero every output.

// File: rtl/sgrc_pkg.sv
package sgrc_pkg;

   typedef enum logic [1:0] {
      SPD_10M  = 2'b00,
      SPD_100M = 2'b01,
      SPD_1G   = 2'b10
   } sgrc_speed_e;

   function automatic sgrc_speed_e sgrc_decode(input logic [1:0] sel);
      sgrc_speed_e s;
      case (sel)
         2'b00:   s = SPD_10M;
         2'b01:   s = SPD_100M;
         default: s = SPD_1G;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/sgrc_mode_ctl.sv
module sgrc_mode_ctl
   import sgrc_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic [1:0]  sel,
   output sgrc_speed_e mode_q,
   output logic        restart,
   output logic        hold_q
);
   sgrc_speed_e sel_dec;

   assign sel_dec = sgrc_decode(sel);
   assign restart = rst | (sel_dec != mode_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= SPD_10M;
         hold_q <= 1'b1;
      end else begin
         mode_q <= sel_dec;
         hold_q <= restart;
      end
   end

   // R8: a restart always leaves one hold cycle behind it
   a_r8_hold_after_restart: assert property (@(posedge clk) disable iff (rst)
      restart |=> hold_q);

   // R9: the mode stays put while no restart is seen
   a_r9_mode_stable: assert property (@(posedge clk) disable iff (rst)
      !restart |=> $stable(mode_q));

endmodule

// File: rtl/sgrc_divider.sv
module sgrc_divider
   import sgrc_pkg::*;
#(
   parameter int DIV_FAST = 10,
   parameter int DIV_SLOW = 100,
   localparam int CW = $clog2(DIV_SLOW)
)(
   input  logic          clk,
   input  logic          rst,
   input  sgrc_speed_e   mode_q,
   input  logic          restart,
   input  logic          hold_q,
   output logic [CW-1:0] cnt_q,
   output logic          at_mid,
   output logic          at_last,
   output logic          en
);
   localparam logic [CW-1:0] LAST_FAST = CW'(DIV_FAST - 1);
   localparam logic [CW-1:0] LAST_SLOW = CW'(DIV_SLOW - 1);
   localparam logic [CW-1:0] MID_FAST  = CW'(DIV_FAST / 2 - 1);
   localparam logic [CW-1:0] MID_SLOW  = CW'(DIV_SLOW / 2 - 1);

   logic          is_gig;
   logic [CW-1:0] last_v;
   logic [CW-1:0] mid_v;

   assign is_gig  = (mode_q == SPD_1G);
   assign last_v  = (mode_q == SPD_100M) ? LAST_FAST : LAST_SLOW;
   assign mid_v   = (mode_q == SPD_100M) ? MID_FAST  : MID_SLOW;
   assign at_mid  = !is_gig && (cnt_q == mid_v);
   assign at_last = !is_gig && (cnt_q == last_v);
   assign en      = !hold_q && (is_gig || cnt_q == '0);

   always_ff @(posedge clk) begin
      if (restart || is_gig)
         cnt_q <= '0;
      else if (cnt_q == last_v)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   // R4 / R5: the counter never leaves the range of the selected divisor
   a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= last_v);

   // R8: a restart clears the counter
   a_r8_cnt_cleared: assert property (@(posedge clk) disable iff (rst)
      restart |=> cnt_q == '0);

   // R3: the enable is steady at gigabit rate outside the hold cycle
   a_r3_gig_enable: assert property (@(posedge clk) disable iff (rst)
      (is_gig && !hold_q) |-> en);

endmodule

// File: rtl/sgrc_halves.sv
module sgrc_halves
   import sgrc_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  sgrc_speed_e mode_q,
   input  logic        restart,
   input  logic        hold_q,
   input  logic        at_mid,
   input  logic        at_last,
   input  logic        en,
   output logic        half_rise,
   output logic        half_fall
);
   logic is_gig;
   assign is_gig = (mode_q == SPD_1G);

   always_ff @(posedge clk) begin
      if (restart || is_gig)
         half_rise <= 1'b0;
      else if (at_mid)
         half_rise <= 1'b1;
      else if (at_last)
         half_rise <= 1'b0;
   end

   always_ff @(negedge clk) begin
      if (rst || hold_q)
         half_fall <= 1'b0;
      else if (is_gig)
         half_fall <= 1'b1;
      else
         half_fall <= half_rise;
   end

   // R6: in a divided mode the falling half repeats the rising half
   a_r6_fall_tracks_rise: assert property (@(posedge clk) disable iff (rst)
      (!is_gig && !hold_q) |-> half_fall == half_rise);

   // R7: a divided-mode strobe falls where the rising half drops
   a_r7_en_at_fall: assert property (@(posedge clk) disable iff (rst)
      (en && !is_gig) |-> (!half_rise && $past(half_rise)));

   // R2: fixed levels at gigabit rate
   a_r2_gig_levels: assert property (@(posedge clk) disable iff (rst)
      (is_gig && !hold_q) |-> (!half_rise && half_fall));

endmodule

// File: rtl/sgmii_rate_clkgen.sv
module sgmii_rate_clkgen
   import sgrc_pkg::*;
#(
   parameter int DIV_FAST = 10,
   parameter int DIV_SLOW = 100
)(
   input  logic       clk_ref,
   input  logic       rst,
   input  logic [1:0] speed_sel,
   output logic       clk_half_rise,
   output logic       clk_half_fall,
   output logic       clk_en
);
   localparam int CW = $clog2(DIV_SLOW);

   generate
      if (DIV_FAST < 2 || (DIV_FAST % 2) != 0) begin : g_bad_fast
         $error("DIV_FAST must be an even value of at least 2");
      end
      if (DIV_SLOW <= DIV_FAST || (DIV_SLOW % 2) != 0) begin : g_bad_slow
         $error("DIV_SLOW must be even and larger than DIV_FAST");
      end
   endgenerate

   sgrc_speed_e   mode_q;
   logic          restart;
   logic          hold_q;
   logic [CW-1:0] cnt_q;
   logic          at_mid;
   logic          at_last;

   sgrc_mode_ctl u_mode (
      .clk     (clk_ref),
      .rst     (rst),
      .sel     (speed_sel),
      .mode_q  (mode_q),
      .restart (restart),
      .hold_q  (hold_q)
   );

   sgrc_divider #(
      .DIV_FAST (DIV_FAST),
      .DIV_SLOW (DIV_SLOW)
   ) u_div (
      .clk     (clk_ref),
      .rst     (rst),
      .mode_q  (mode_q),
      .restart (restart),
      .hold_q  (hold_q),
      .cnt_q   (cnt_q),
      .at_mid  (at_mid),
      .at_last (at_last),
      .en      (clk_en)
   );

   sgrc_halves u_halves (
      .clk       (clk_ref),
      .rst       (rst),
      .mode_q    (mode_q),
      .restart   (restart),
      .hold_q    (hold_q),
      .at_mid    (at_mid),
      .at_last   (at_last),
      .en        (clk_en),
      .half_rise (clk_half_rise),
      .half_fall (clk_half_fall)
   );

   // R8: after a restart both halves and the enable read low
   a_r8_outputs_cleared: assert property (@(posedge clk_ref) disable iff (rst)
      restart |=> (!clk_half_rise && !clk_en));

endmodule

// File: tb/tb_sgmii_rate_clkgen.sv
module tb_sgmii_rate_clkgen;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] sel = 2'b00;
   logic       h_rise, h_fall, en;

   int vectors = 0;
   int miscomp = 0;
   bit done    = 1'b0;

   logic s_rise, s_en, s_fall;

   always #2.5 clk = ~clk;

   sgmii_rate_clkgen dut (
      .clk_ref       (clk),
      .rst           (rst),
      .speed_sel     (sel),
      .clk_half_rise (h_rise),
      .clk_half_fall (h_fall),
      .clk_en        (en)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscomp++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // one reference cycle: rising-edge outputs after posedge, falling half after negedge
   task automatic step();
      @(posedge clk); #1;
      s_rise = h_rise;
      s_en   = en;
      @(negedge clk); #1;
      s_fall = h_fall;
   endtask

   task automatic set_speed(input logic [1:0] s);
      @(negedge clk);
      sel = s;
   endtask

   // divided mode: R4/R5 period and duty, R6 fall half, R7 strobe, R8 restart start
   task automatic test_divided(input logic [1:0] s, input int n, input string rq);
      int hi_len, last_rise_k, last_en_k, first_en_k;
      logic prev_rise;
      set_speed(s);
      hi_len = 0; last_rise_k = -1; last_en_k = -1; first_en_k = -1;
      prev_rise = 1'b0;
      for (int k = 0; k < 3 * n; k++) begin
         step();
         if (k == 0) begin
            chk("R8", "restart rise half", s_rise, 0);
            chk("R8", "restart fall half", s_fall, 0);
            chk("R8", "restart enable", s_en, 0);
         end
         if (s_rise != ((k % n) >= n / 2))
            chk(rq, "rise half level", s_rise, ((k % n) >= n / 2) ? 1 : 0);
         if (s_fall != s_rise) chk("R6", "fall half vs rise half", s_fall, s_rise);
         if (s_en != (k >= n && (k % n) == 0))
            chk("R7", "strobe position", s_en, (k >= n && (k % n) == 0) ? 1 : 0);
         if (s_en) begin
            chk("R7", "strobe at high-to-low", {prev_rise, s_rise}, 2);
            if (first_en_k < 0) first_en_k = k;
            if (last_en_k >= 0) chk("R7", "strobe spacing", k - last_en_k, n);
            last_en_k = k;
         end
         if (s_rise && !prev_rise) begin
            if (last_rise_k >= 0) chk(rq, "forwarded period", k - last_rise_k, n);
            last_rise_k = k;
            hi_len = 0;
         end
         if (s_rise) hi_len++;
         if (!s_rise && prev_rise) chk(rq, "forwarded high time", hi_len, n / 2);
         prev_rise = s_rise;
      end
      chk("R8", "first strobe after restart", first_en_k, n);
   endtask

   task automatic test_gig(input logic [1:0] s, input bit expect_restart);
      int bad_r, bad_f, bad_e;
      set_speed(s);
      bad_r = 0; bad_f = 0; bad_e = 0;
      for (int k = 0; k < 30; k++) begin
         step();
         if (k == 0 && expect_restart) begin
            chk("R8", "gig restart rise", s_rise, 0);
            chk("R8", "gig restart fall", s_fall, 0);
            chk("R8", "gig restart enable", s_en, 0);
         end else begin
            if (s_rise != 1'b0) bad_r++;
            if (s_fall != 1'b1) bad_f++;
            if (s_en != 1'b1) bad_e++;
         end
      end
      if (expect_restart) begin
         chk("R2", "gig rise half not 0 (cycles)", bad_r, 0);
         chk("R2", "gig fall half not 1 (cycles)", bad_f, 0);
         chk("R3", "gig enable low (cycles)", bad_e, 0);
      end else begin
         chk("R9", "rise half disturbed (cycles)", bad_r, 0);
         chk("R9", "fall half disturbed (cycles)", bad_f, 0);
         chk("R9", "enable interrupted (cycles)", bad_e, 0);
      end
   endtask

   task automatic test_reset();
      @(negedge clk);
      rst = 1'b1;
      step();
      chk("R8", "reset rise half", s_rise, 0);
      chk("R8", "reset fall half", s_fall, 0);
      chk("R8", "reset enable", s_en, 0);
      step();
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
         $finish;
      end
   endtask

   initial begin
      #100000;
      vectors++;
      miscomp++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      sel = 2'b00;
      rst = 1'b1;
      repeat (3) step();
      chk("R8", "initial rise half", s_rise, 0);
      chk("R8", "initial fall half", s_fall, 0);
      chk("R8", "initial enable", s_en, 0);
      @(negedge clk);
      rst = 1'b0;
      repeat (5) step();
      test_divided(2'b01, 10, "R4");   // R1: 01 is 100 Mb/s
      test_divided(2'b00, 100, "R5");  // R1: 00 is 10 Mb/s
      test_gig(2'b10, 1'b1);           // R1: 10 is 1 Gb/s
      test_gig(2'b11, 1'b0);           // R1, R9: 11 also 1 Gb/s, no restart
      test_divided(2'b01, 10, "R4");
      test_reset();
      test_gig(2'b10, 1'b1);
      test_divided(2'b00, 100, "R5");
      finish_run();
   end

endmodule